// File: doc/BRIEF.md
# Buffered 16-bit timer/counter

A 16-bit up-counter attached to an 8-bit register bus. The count advances from one of two sources: an internal tick that fires once every four system clocks, or rising edges on an external input pin. Both sources go through a prescaler with a ratio of 1, 2, 4 or 8. When the count wraps from 0xFFFF to 0x0000, a sticky overflow flag is set.

Software sees three byte registers: the low count byte, the high count byte and a control register. In wide mode the high-byte address maps to a holding byte. A low-byte read copies the live upper byte into the holding byte, and a low-byte write commits the holding byte together with the new low byte. Software can therefore read or load all sixteen bits coherently while the counter runs. In external mode a rising edge is only counted once a falling edge has been seen since the last count write or enable. This stops a pin that is already high, or that rises right after a reload, from adding a count.

Top module: `buf_timer16`

## Requirements
- R1: After reset the low byte (address 0), the high byte (address 1) and the control register (address 2) all read 0x00, and `ovf_flag` is 0.
- R2: With control bit 0 (enable) set and bit 1 (source) clear, the count rises by exactly one for every 4·N system clocks, where N = 1, 2, 4 or 8 for control bits [4:3] = 0, 1, 2 or 3.
- R3: A counter wrap from 0xFFFF to 0x0000 sets `ovf_flag` and control bit 7. The flag stays set until a control write with bit 7 = 0; a control write with bit 7 = 1 leaves it set.
- R4: In wide mode (control bit 5 = 1), a read of address 0 copies the live upper byte into the holding byte, and reads of address 1 return the holding byte, not the live upper byte.
- R5: In wide mode a write to address 1 changes only the holding byte, leaving the live count unchanged. A write to address 0 loads the whole count with {holding byte, written byte}.
- R6: In narrow mode (control bit 5 = 0), addresses 0 and 1 read and write the live count bytes directly, and a high-byte write takes effect at once.
- R7: A write to address 0 clears the prescaler's partial count. A write to address 1 does not.
- R8: With control bit 1 set, rising edges of `ext_pin` advance the count. With control bit 2 = 0 the pin passes through a two-stage synchronizer, and a rise shows in the count three clock edges after the pin changes. With bit 2 = 1 the pin skips the second stage and shows after two edges.
- R9: After reset, after any write to address 0 or 1, and after the enable bit goes from 0 to 1, no rising edge of `ext_pin` is counted until a falling edge has been detected.
- R10: With the enable bit clear the count holds, whatever the internal tick or `ext_pin` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (needed for the wide-mode latch) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| ext_pin | input | 1 | External count input, asynchronous |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Assertions check on every cycle that the prescaler's partial count never passes the selected limit and that every counter advance is exactly plus one. They also check that the count holds while the block is disabled and during a wide-mode high-byte write, that the overflow flag only clears on a clearing control write, and that edge qualification only arms after a falling edge. The bench scenarios cover the rest: the exact tick rate for each prescaler ratio, the stale and refreshed holding byte around a carry into the upper byte, and the difference in clearing the prescaler between low-byte and high-byte writes. They also show the one-cycle latency gap between the synchronized and unsynchronized pin paths, and the first rise being ignored after a reload or after enabling with the pin low.

// File: rtl/buf_timer16_pkg.sv
// Package: shared constants for the buffered timer.
// Assumes a 2-bit register address and the control bit positions below.
package buf_timer16_pkg;
    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int CB_EN    = 0;
    localparam int CB_EXT   = 1;
    localparam int CB_ASYNC = 2;
    localparam int CB_PSC   = 3;
    localparam int CB_WIDE  = 5;
    localparam int CB_OVF   = 7;

    typedef struct packed {
        logic       wide;
        logic [1:0] psc;
        logic       async_in;
        logic       ext_src;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/buf_timer16_prescale.sv
// Prescaler: passes one event in every 2**sel events.
// Assumes the event input is a single-cycle pulse. A clear resets the partial
// count. A new ratio applies from the next comparison against the limit.
module buf_timer16_prescale #(
    parameter int SEL_W = 2,
    localparam int PW = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev,
    input  logic [SEL_W-1:0] sel,
    output logic             out
);
    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    // Limit: the low 'sel' bits set, giving a terminal count of 2**sel - 1.
    always_comb begin
        lim = '0;
        for (int i = 0; i < PW; i++) lim[i] = (i < int'(sel));
    end

    assign out = ev && (pcnt >= lim);

    // Partial event count, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pcnt <= '0;
        else if (ev)        pcnt <= (pcnt >= lim) ? '0 : pcnt + 1'b1;
    end

    // R2: the partial count stays within the current limit after an event.
    p_psc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !clr) |=> (pcnt <= $past(lim)));
endmodule

// File: rtl/buf_timer16_extin.sv
// External input stage: synchronizer, edge detect and first-edge qualification.
// Assumes pin is asynchronous. The unsynchronized path uses only the first
// sampling flop. 'disarm' is a one-cycle pulse that needs a falling edge
// to be seen again before a rise is reported.
module buf_timer16_extin #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic async_sel,
    input  logic disarm,
    output logic rise_q
);
    logic [SYNC_STAGES-1:0] sreg;
    logic lvl, prev, rise, fall, armed;

    // Sampling chain; stage 0 alone serves the unsynchronized path.
    always_ff @(posedge clk) begin
        if (!rst_n) sreg <= '0;
        else        sreg <= {sreg[SYNC_STAGES-2:0], pin};
    end

    assign lvl = async_sel ? sreg[0] : sreg[SYNC_STAGES-1];

    // Previous level of the selected path, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl && !prev;
    assign fall = !lvl && prev;

    // Qualification: arm on a falling edge, drop on disarm or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || disarm) armed <= 1'b0;
        else if (fall)        armed <= 1'b1;
    end

    assign rise_q = rise && armed;

    // R9: arming only ever follows a detected falling edge.
    p_arm_needs_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(fall));
endmodule

// File: rtl/buf_timer16.sv
// Top: 16-bit timer/counter with byte register access and an optional
// coherent (wide) mode through a holding byte.
// Assumes single-cycle bus strobes and a synchronous active-low reset.
module buf_timer16
    import buf_timer16_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 2,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_pin,
    output logic              ovf_flag
);
    localparam int CNT_W = 2 * DATA_W;

    ctrl_t             ctrl;
    logic              ovf, en_d;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] hbuf;
    logic [DIV_W-1:0]  div;
    logic wr_lo, wr_hi, wr_ctrl, rd_lo;
    logic tick, ext_rise, ev, psc_out, inc, disarm;

    assign wr_lo   = bus_wr && (bus_addr == ADDR_LO);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_HI);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign rd_lo   = bus_rd && (bus_addr == ADDR_LO);

    // Free-running divider that gives the quarter-rate internal tick.
    always_ff @(posedge clk) begin
        if (!rst_n) div <= '0;
        else        div <= div + 1'b1;
    end
    assign tick = &div;

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_ctrl) begin
            ctrl.en       <= bus_wdata[CB_EN];
            ctrl.ext_src  <= bus_wdata[CB_EXT];
            ctrl.async_in <= bus_wdata[CB_ASYNC];
            ctrl.psc      <= bus_wdata[CB_PSC +: 2];
            ctrl.wide     <= bus_wdata[CB_WIDE];
        end
    end

    // Delayed enable, for detecting the enable's rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= ctrl.en;
    end

    assign disarm = wr_lo || wr_hi || (ctrl.en && !en_d);

    buf_timer16_extin #(.SYNC_STAGES(SYNC_STAGES)) u_extin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .async_sel (ctrl.async_in),
        .disarm    (disarm),
        .rise_q    (ext_rise)
    );

    assign ev = ctrl.en && (ctrl.ext_src ? ext_rise : tick);

    buf_timer16_prescale #(.SEL_W(SEL_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_lo),
        .ev    (ev),
        .sel   (ctrl.psc),
        .out   (psc_out)
    );

    assign inc = psc_out && !wr_lo && !wr_hi;

    // Live count: bus writes take priority over increments.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (wr_lo)             cnt <= {(ctrl.wide ? hbuf : cnt[CNT_W-1:DATA_W]), bus_wdata};
        else if (wr_hi && !ctrl.wide) cnt[CNT_W-1:DATA_W] <= bus_wdata;
        else if (inc)               cnt <= cnt + 1'b1;
    end

    // Holding byte: loaded by high writes or low reads, in wide mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hbuf <= '0;
        else if (ctrl.wide && wr_hi) hbuf <= bus_wdata;
        else if (ctrl.wide && rd_lo) hbuf <= cnt[CNT_W-1:DATA_W];
    end

    // Sticky overflow: a wrap wins over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ovf <= 1'b0;
        else if (inc && (&cnt))               ovf <= 1'b1;
        else if (wr_ctrl && !bus_wdata[CB_OVF]) ovf <= 1'b0;
    end
    assign ovf_flag = ovf;

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            ADDR_LO:   bus_rdata = cnt[DATA_W-1:0];
            ADDR_HI:   bus_rdata = ctrl.wide ? hbuf : cnt[CNT_W-1:DATA_W];
            ADDR_CTRL: bus_rdata = {ovf, 1'b0, ctrl.wide, ctrl.psc,
                                    ctrl.async_in, ctrl.ext_src, ctrl.en};
            default:   bus_rdata = '0;
        endcase
    end

    // R2: every counter advance is exactly one step.
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt == $past(cnt) + 1'b1));
    // R10: disabled and not written means the count holds.
    p_hold_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !wr_lo && !wr_hi) |=> $stable(cnt));
    // R5: a wide-mode high-byte write leaves the live count untouched.
    p_wide_hi_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.wide && wr_hi) |=> $stable(cnt));
    // R3: the flag only falls on a clearing control write.
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_ctrl && !bus_wdata[CB_OVF])) |=> ovf);
endmodule

// File: tb/buf_timer16_bench.sv
module buf_timer16_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    buf_timer16 u_buf_timer16 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        ext_pin = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            set_pin(1'b0);
            set_pin(1'b1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v1, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); chk("R1 lo", v, 8'h00);
        rd(2'd1, v); chk("R1 hi", v, 8'h00);
        rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 ovf", ovf_flag, 0);

        // R2: internal tick rate for every prescaler ratio
        for (int p = 0; p < 4; p++) begin
            wr(2'd2, 8'h01 | 8'(p << 3));
            rd(2'd0, v1);
            repeat (20 * (1 << p) - 1) @(negedge clk);
            rd(2'd0, v2);
            chk($sformatf("R2 ratio %0d", 1 << p), int'(8'(v2 - v1)), 5);
        end

        // R3: overflow set, write-1 ignored, write-0 clears
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h01);
        repeat (12) @(negedge clk);
        chk("R3 flag set", ovf_flag, 1);
        wr(2'd2, 8'h80);
        rd(2'd2, v); chk("R3 write one keeps", v, 8'h80);
        rd(2'd1, v); chk("R3 wrapped hi", v, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R3 cleared", v, 8'h00);
        chk("R3 pin cleared", ovf_flag, 0);

        // R10: internal tick ignored while disabled
        rd(2'd0, v1);
        repeat (40) @(negedge clk);
        rd(2'd0, v2); chk("R10 internal hold", v2, v1);

        // R9: first rise after enable with pin low is ignored
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h07);
        set_pin(1'b1);
        rd(2'd0, v); chk("R9 rise before fall", v, 8'h00);
        pulse(1);
        rd(2'd0, v); chk("R8 async count", v, 8'h01);
        pulse(1);
        rd(2'd0, v); chk("R8 second edge", v, 8'h02);
        // R9: count write while armed disarms
        set_pin(1'b0);
        wr(2'd0, 8'h10);
        set_pin(1'b1);
        rd(2'd0, v); chk("R9 rise after write", v, 8'h10);
        pulse(1);
        rd(2'd0, v); chk("R9 rearmed", v, 8'h11);

        // R8: latency of synchronized versus unsynchronized path
        wr(2'd2, 8'h03);
        set_pin(1'b0);
        @(negedge clk); bus_addr = 2'd0; ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 chk("R8 sync not yet", bus_rdata, 8'h11);
        repeat (3) @(negedge clk);
        #1 chk("R8 sync counted", bus_rdata, 8'h12);
        wr(2'd2, 8'h07);
        set_pin(1'b0);
        @(negedge clk); bus_addr = 2'd0; ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 chk("R8 async two edges", bus_rdata, 8'h13);
        repeat (4) @(negedge clk);

        // R10: external edges ignored while disabled
        wr(2'd2, 8'h06);
        pulse(2);
        rd(2'd0, v); chk("R10 ext hold", v, 8'h13);
        wr(2'd2, 8'h07);
        pulse(1);
        rd(2'd0, v); chk("R9 re-enable pin high", v, 8'h14);
        set_pin(1'b0);
        wr(2'd2, 8'h06);
        wr(2'd2, 8'h07);
        set_pin(1'b1);
        rd(2'd0, v); chk("R9 enable while low", v, 8'h14);
        pulse(1);
        rd(2'd0, v); chk("R9 after fall", v, 8'h15);

        // R7: low write clears prescaler, high write does not (ratio 4)
        wr(2'd2, 8'h17);
        wr(2'd0, 8'h00);
        pulse(3);
        rd(2'd0, v); chk("R7 partial", v, 8'h00);
        wr(2'd1, 8'h00);
        pulse(1);
        rd(2'd0, v); chk("R7 hi write keeps", v, 8'h01);
        pulse(3);
        wr(2'd0, 8'h01);
        pulse(1);
        rd(2'd0, v); chk("R7 lo write clears", v, 8'h01);
        pulse(3);
        rd(2'd0, v); chk("R7 full ratio", v, 8'h02);

        // R5/R4: wide mode holding byte
        wr(2'd2, 8'h27);
        wr(2'd1, 8'h12);
        wr(2'd2, 8'h07);
        rd(2'd1, v); chk("R5 live hi untouched", v, 8'h00);
        rd(2'd0, v); chk("R5 live lo untouched", v, 8'h02);
        wr(2'd2, 8'h27);
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R5 commit lo", v, 8'hFF);
        rd(2'd1, v); chk("R4 buffer hi", v, 8'h12);
        pulse(1);
        rd(2'd1, v); chk("R4 stale buffer", v, 8'h12);
        rd(2'd0, v); chk("R4 carried lo", v, 8'h00);
        rd(2'd1, v); chk("R4 refreshed", v, 8'h13);

        // R6: narrow mode direct high write
        wr(2'd2, 8'h07);
        wr(2'd1, 8'h5A);
        rd(2'd1, v); chk("R6 direct hi", v, 8'h5A);
        rd(2'd0, v); chk("R6 lo kept", v, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule